// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting timer channel with four operating modes: terminal-count interrupt, hardware-retriggerable one-shot, rate generator and square-wave generator. A host-side loader supplies the mode through a configuration strobe and the initial count through a count strobe. A separate strobe marks that only the first byte of a two-byte count has arrived. Counting advances only on cycles where the `tick` enable is high. `tick` takes the place of the counter clock pulse, and all logic runs on the single system clock.

The `gate` input serves two purposes, depending on the mode. As a level it enables or suspends counting. Its rising edge is a trigger. A trigger is remembered until the next tick consumes it. The block presents the live value of its counting element, the output level, and a flag that shows whether a written count is still waiting to be transferred into the counting element. Counting is binary only. An initial count of 0 stands for 65536.

Top module: `pic_interval_counter`

## Requirements
- R1: After reset, `out_o` is 0, `count_o` is 0, `null_o` is 0 and the mode is terminal-count (`cfg_mode` encoding: 0 terminal-count, 1 one-shot, 2 rate generator, 3 square wave).
- R2: `count_o` changes only on a clock edge at which `tick` is high; host writes alone never alter it.
- R3: In terminal-count mode, a configuration write drives `out_o` low. A count of N is copied on the first tick without a decrement, and `out_o` rises on tick N+1 when the count reaches 0. It then stays high, while counting continues, until the next count or configuration write.
- R4: In terminal-count mode, a partial (first-byte) write forces `out_o` low on the next clock and freezes the count until the full count is written. While `gate` is low, ticks do not decrement, and `out_o` is unaffected.
- R5: In one-shot mode, `out_o` is high after configuration, and ticks without a trigger leave the count alone. A trigger loads N on the next tick and drives `out_o` low for exactly N ticks. The `gate` level has no effect.
- R6: In one-shot mode, a trigger during the pulse reloads the most recently written count and restarts the N-tick low phase.
- R7: In rate-generator mode, the count loads on the first tick after the write. `out_o` is low for the single tick period in which the count equals 1. The count then reloads, giving a period of N ticks.
- R8: In rate-generator and square-wave modes, `gate` low stops counting and forces `out_o` high on the next clock. A later trigger reloads the count on the next tick with `out_o` high.
- R9: In rate-generator mode, a count written while counting takes effect at the next reload, not before.
- R10: In square-wave mode with even N, the count loads as N and falls by 2 per tick. On expiry `out_o` toggles and the count reloads, so each half lasts N/2 ticks.
- R11: In square-wave mode with odd N, N-1 is loaded. Expiry while high is held for one extra tick at 0, so the high phase lasts (N+1)/2 ticks and the low phase (N-1)/2 ticks.
- R12: An initial count of 0 acts as 65536: in terminal-count mode `out_o` rises on tick 65537.
- R13: `null_o` goes high on the clock after a full count write and clears when the count register is transferred into the counting element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter clock-pulse enable |
| gate | input | 1 | Gate level; a rising edge is a trigger |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode code written with `cfg_wr` |
| cnt_wr | input | 1 | Completed count write strobe |
| cnt_partial | input | 1 | First byte of a two-byte count written |
| cnt_val | input | CNT_W | Initial count written with `cnt_wr` |
| count_o | output | CNT_W | Live counting-element value |
| out_o | output | 1 | Counter output level |
| null_o | output | 1 | Written count not yet transferred |

## Verification
Some properties are checked on every cycle: the count holds on every non-tick cycle, the terminal-count output stays high once raised and is low after configuration and after a partial write, gate-low forces the output high in the periodic modes, and the null flag follows every count write. The bench scenarios are needed for the properties that depend on a tick sequence. These are the exact loading delays, the N-tick one-shot width and its retrigger extension, the rate-generator period and deferred reload, the even and odd square-wave phase lengths, and the 65536 case.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        MD_TERM    = 2'd0,
        MD_ONESHOT = 2'd1,
        MD_RATE    = 2'd2,
        MD_SQUARE  = 2'd3
    } pic_mode_e;
endpackage

// File: rtl/pic_gate_sense.sv
module pic_gate_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic consume,
    input  logic clr,
    output logic trig
);
    typedef struct packed {
        logic gate_prev;
        logic pend;
    } gs_t;

    gs_t s_d, s_q;
    logic rise;

    always_comb begin
        rise = gate & ~s_q.gate_prev;
        trig = rise | s_q.pend;
        s_d = s_q;
        s_d.gate_prev = gate;
        if (clr || consume) s_d.pend = 1'b0;
        else                s_d.pend = trig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pic_step.sv
module pic_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic         by_two,
    output logic [W-1:0] nxt,
    output logic         nxt_zero,
    output logic         nxt_one
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    always_comb begin
        nxt      = cur - (by_two ? TWO : ONE);
        nxt_zero = (nxt == '0);
        nxt_one  = (nxt == ONE);
    end
endmodule

// File: rtl/pic_interval_counter.sv
module pic_interval_counter
    import pic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_mode,
    input  logic             cnt_wr,
    input  logic             cnt_partial,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o,
    output logic             null_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        pic_mode_e        mode;
        logic [CNT_W-1:0] cr;
        logic [CNT_W-1:0] ce;
        logic             out;
        logic             nul;
        logic             pend;
        logic             run;
        logic             hold;
        logic             odd;
        logic             ext;
    } st_t;

    st_t s_d, s_q;

    logic             host_wr;
    logic             tick_eff;
    logic             trig;
    logic [CNT_W-1:0] nxt;
    logic             nxt_zero;
    logic             nxt_one;
    logic [CNT_W-1:0] load_val;

    assign host_wr  = cfg_wr | cnt_wr | cnt_partial;
    assign tick_eff = tick & ~host_wr;

    pic_gate_sense u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate    (gate),
        .consume (tick_eff),
        .clr     (cfg_wr),
        .trig    (trig)
    );

    pic_step #(.W(CNT_W)) u_step (
        .cur      (s_q.ce),
        .by_two   (s_q.mode == MD_SQUARE),
        .nxt      (nxt),
        .nxt_zero (nxt_zero),
        .nxt_one  (nxt_one)
    );

    always_comb begin
        load_val = (s_q.mode == MD_SQUARE) ? {s_q.cr[CNT_W-1:1], 1'b0} : s_q.cr;
        s_d = s_q;
        if (cfg_wr) begin
            s_d.mode = pic_mode_e'(cfg_mode);
            s_d.out  = (pic_mode_e'(cfg_mode) != MD_TERM);
            s_d.pend = 1'b0;
            s_d.run  = 1'b0;
            s_d.hold = 1'b0;
            s_d.ext  = 1'b0;
        end else if (cnt_partial) begin
            if (s_q.mode == MD_TERM) begin
                s_d.hold = 1'b1;
                s_d.out  = 1'b0;
            end
        end else if (cnt_wr) begin
            s_d.cr   = cnt_val;
            s_d.nul  = 1'b1;
            s_d.hold = 1'b0;
            case (s_q.mode)
                MD_TERM: begin
                    s_d.pend = 1'b1;
                    s_d.out  = 1'b0;
                end
                MD_RATE, MD_SQUARE: if (!s_q.run) s_d.pend = 1'b1;
                default: ;
            endcase
        end else if (tick) begin
            case (s_q.mode)
                MD_TERM: begin
                    if (s_q.hold) begin
                        s_d.ce = s_q.ce;
                    end else if (s_q.pend) begin
                        s_d.ce   = s_q.cr;
                        s_d.pend = 1'b0;
                        s_d.nul  = 1'b0;
                        s_d.run  = 1'b1;
                    end else if (s_q.run && gate) begin
                        s_d.ce = nxt;
                        if (nxt_zero) s_d.out = 1'b1;
                    end
                end
                MD_ONESHOT: begin
                    if (trig) begin
                        s_d.ce  = s_q.cr;
                        s_d.nul = 1'b0;
                        s_d.out = 1'b0;
                        s_d.run = 1'b1;
                    end else if (s_q.run) begin
                        s_d.ce = nxt;
                        if (!s_q.out && nxt_zero) s_d.out = 1'b1;
                    end
                end
                MD_RATE: begin
                    if (gate) begin
                        if (s_q.pend || trig) begin
                            s_d.ce   = s_q.cr;
                            s_d.nul  = 1'b0;
                            s_d.pend = 1'b0;
                            s_d.run  = 1'b1;
                            s_d.out  = 1'b1;
                        end else if (s_q.run) begin
                            if (s_q.ce == CNT_ONE) begin
                                s_d.ce  = s_q.cr;
                                s_d.nul = 1'b0;
                                s_d.out = 1'b1;
                            end else begin
                                s_d.ce  = nxt;
                                s_d.out = ~nxt_one;
                            end
                        end
                    end
                end
                default: begin
                    if (gate) begin
                        if (s_q.pend || trig) begin
                            s_d.ce   = load_val;
                            s_d.odd  = s_q.cr[0];
                            s_d.nul  = 1'b0;
                            s_d.pend = 1'b0;
                            s_d.run  = 1'b1;
                            s_d.out  = 1'b1;
                            s_d.ext  = 1'b0;
                        end else if (s_q.run) begin
                            if (s_q.ext) begin
                                s_d.ce  = load_val;
                                s_d.odd = s_q.cr[0];
                                s_d.nul = 1'b0;
                                s_d.out = 1'b0;
                                s_d.ext = 1'b0;
                            end else if (nxt_zero) begin
                                if (s_q.odd && s_q.out) begin
                                    s_d.ce  = nxt;
                                    s_d.ext = 1'b1;
                                end else begin
                                    s_d.ce  = load_val;
                                    s_d.odd = s_q.cr[0];
                                    s_d.nul = 1'b0;
                                    s_d.out = ~s_q.out;
                                end
                            end else begin
                                s_d.ce = nxt;
                            end
                        end
                    end
                end
            endcase
        end
        if (!cfg_wr && !gate && (s_q.mode == MD_RATE || s_q.mode == MD_SQUARE))
            s_d.out = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.ce;
    assign out_o   = s_q.out;
    assign null_o  = s_q.nul;

    p_count_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_o));

    p_cfg_term_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_mode == 2'd0 |=> !out_o);

    p_term_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.mode == MD_TERM && out_o && !host_wr |=> out_o);

    p_partial_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr && cnt_partial && s_q.mode == MD_TERM |=> !out_o && $stable(count_o));

    p_gate_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr && !gate && (s_q.mode == MD_RATE || s_q.mode == MD_SQUARE) |=> out_o);

    p_null_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr && !cfg_wr && !cnt_partial |=> null_o);
endmodule

// File: tb/tb_pic_interval_counter.sv
module tb_pic_interval_counter;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         gate = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [1:0]   cfg_mode = 2'd0;
    logic         cnt_wr = 1'b0;
    logic         cnt_partial = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic [W-1:0] count_o;
    logic         out_o;
    logic         null_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        string        req;
        bit           chk_out;
        logic         e_out;
        bit           chk_cnt;
        logic [W-1:0] e_cnt;
        bit           chk_nul;
        logic         e_nul;
    } exp_t;

    exp_t sbq[$];

    always #4 clk = ~clk;

    pic_interval_counter #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate),
        .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cnt_wr(cnt_wr),
        .cnt_partial(cnt_partial), .cnt_val(cnt_val),
        .count_o(count_o), .out_o(out_o), .null_o(null_o)
    );

    // Monitor: pop and compare on the falling edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            exp_t it;
            it = sbq.pop_front();
            if (it.chk_out) begin
                checks++;
                if (out_o !== it.e_out) begin
                    errors++;
                    $display("FAIL %s out_o actual=%0b expected=%0b", it.req, out_o, it.e_out);
                end
            end
            if (it.chk_cnt) begin
                checks++;
                if (count_o !== it.e_cnt) begin
                    errors++;
                    $display("FAIL %s count_o actual=%0d expected=%0d", it.req, count_o, it.e_cnt);
                end
            end
            if (it.chk_nul) begin
                checks++;
                if (null_o !== it.e_nul) begin
                    errors++;
                    $display("FAIL %s null_o actual=%0b expected=%0b", it.req, null_o, it.e_nul);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic tk();
        tick = 1'b1; cyc(); tick = 1'b0;
    endtask

    task automatic wcfg(input logic [1:0] m);
        cfg_wr = 1'b1; cfg_mode = m; cyc(); cfg_wr = 1'b0;
    endtask

    task automatic wcnt(input logic [W-1:0] v);
        cnt_wr = 1'b1; cnt_val = v; cyc(); cnt_wr = 1'b0;
    endtask

    task automatic wpart();
        cnt_partial = 1'b1; cyc(); cnt_partial = 1'b0;
    endtask

    task automatic gset(input logic v);
        gate = v; cyc();
    endtask

    task automatic ex(input string r, input logic o, input logic [W-1:0] c);
        exp_t it;
        it = '{req: r, chk_out: 1'b1, e_out: o, chk_cnt: 1'b1, e_cnt: c, chk_nul: 1'b0, e_nul: 1'b0};
        sbq.push_back(it);
    endtask

    task automatic exo(input string r, input logic o);
        exp_t it;
        it = '{req: r, chk_out: 1'b1, e_out: o, chk_cnt: 1'b0, e_cnt: '0, chk_nul: 1'b0, e_nul: 1'b0};
        sbq.push_back(it);
    endtask

    task automatic exn(input string r, input logic n);
        exp_t it;
        it = '{req: r, chk_out: 1'b0, e_out: 1'b0, chk_cnt: 1'b0, e_cnt: '0, chk_nul: 1'b1, e_nul: n};
        sbq.push_back(it);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        ex("R1", 1'b0, 16'd0);
        exn("R1", 1'b0);

        // R3 terminal count with N=5, R13 null flag
        wcfg(2'd0);            exo("R3", 1'b0);
        wcnt(16'd5);           exn("R13", 1'b1); ex("R3", 1'b0, 16'd0);
        gset(1'b1);
        tk();                  ex("R3", 1'b0, 16'd5); exn("R13", 1'b0);
        for (int i = 4; i >= 1; i--) begin
            tk(); ex("R3", 1'b0, W'(i));
        end
        tk();                  ex("R3", 1'b1, 16'd0);
        repeat (3) cyc();      ex("R2", 1'b1, 16'd0);
        tk();                  ex("R3", 1'b1, 16'hFFFF);

        // R4 partial write and gate suspension
        wpart();               ex("R4", 1'b0, 16'hFFFF);
        tk();                  ex("R4", 1'b0, 16'hFFFF);
        wcnt(16'd2);           exn("R13", 1'b1);
        tk();                  ex("R4", 1'b0, 16'd2);
        tk();                  ex("R4", 1'b0, 16'd1);
        gset(1'b0);
        tk();                  ex("R4", 1'b0, 16'd1);
        gset(1'b1);
        tk();                  ex("R4", 1'b1, 16'd0);

        // R5 one-shot N=3
        wcfg(2'd1);            exo("R5", 1'b1);
        wcnt(16'd3);           exo("R5", 1'b1);
        tk();                  ex("R5", 1'b1, 16'd0);
        gset(1'b0);
        gset(1'b1);
        tk();                  ex("R5", 1'b0, 16'd3); exn("R13", 1'b0);
        gset(1'b0);
        tk();                  ex("R5", 1'b0, 16'd2);
        tk();                  ex("R5", 1'b0, 16'd1);
        tk();                  ex("R5", 1'b1, 16'd0);

        // R6 retrigger with a newer count
        gset(1'b1);
        tk();                  ex("R6", 1'b0, 16'd3);
        tk();                  ex("R6", 1'b0, 16'd2);
        wcnt(16'd5);
        gset(1'b0);
        gset(1'b1);
        tk();                  ex("R6", 1'b0, 16'd5);
        gset(1'b0);
        for (int i = 4; i >= 1; i--) begin
            tk(); ex("R6", 1'b0, W'(i));
        end
        tk();                  ex("R6", 1'b1, 16'd0);

        // R7 rate generator N=4
        wcfg(2'd2);            exo("R7", 1'b1);
        gset(1'b1);
        wcnt(16'd4);
        tk();                  ex("R7", 1'b1, 16'd4);
        for (int p = 0; p < 2; p++) begin
            tk(); ex("R7", 1'b1, 16'd3);
            tk(); ex("R7", 1'b1, 16'd2);
            tk(); ex("R7", 1'b0, 16'd1);
            if (p == 0) begin
                tk(); ex("R7", 1'b1, 16'd4);
            end
        end

        // R8 gate low in rate mode
        gset(1'b0);            ex("R8", 1'b1, 16'd1);
        tk();                  ex("R8", 1'b1, 16'd1);
        gset(1'b1);
        tk();                  ex("R8", 1'b1, 16'd4);
        tk();                  ex("R8", 1'b1, 16'd3);

        // R9 deferred reload
        wcnt(16'd6);           exn("R13", 1'b1);
        tk();                  ex("R9", 1'b1, 16'd2);
        tk();                  ex("R9", 1'b0, 16'd1);
        tk();                  ex("R9", 1'b1, 16'd6); exn("R13", 1'b0);
        for (int i = 5; i >= 2; i--) begin
            tk(); ex("R9", 1'b1, W'(i));
        end
        tk();                  ex("R9", 1'b0, 16'd1);
        tk();                  ex("R9", 1'b1, 16'd6);

        // R10 square wave even N=6
        wcfg(2'd3);            exo("R10", 1'b1);
        wcnt(16'd6);
        tk();                  ex("R10", 1'b1, 16'd6);
        tk();                  ex("R10", 1'b1, 16'd4);
        tk();                  ex("R10", 1'b1, 16'd2);
        tk();                  ex("R10", 1'b0, 16'd6);
        tk();                  ex("R10", 1'b0, 16'd4);
        tk();                  ex("R10", 1'b0, 16'd2);
        tk();                  ex("R10", 1'b1, 16'd6);

        // R11 square wave odd N=5
        wcfg(2'd3);
        wcnt(16'd5);
        tk();                  ex("R11", 1'b1, 16'd4);
        tk();                  ex("R11", 1'b1, 16'd2);
        tk();                  ex("R11", 1'b1, 16'd0);
        tk();                  ex("R11", 1'b0, 16'd4);
        tk();                  ex("R11", 1'b0, 16'd2);
        tk();                  ex("R11", 1'b1, 16'd4);
        tk();                  ex("R11", 1'b1, 16'd2);
        tk();                  ex("R11", 1'b1, 16'd0);
        tk();                  ex("R11", 1'b0, 16'd4);

        // R8 gate low in square mode while output is low
        gset(1'b0);            ex("R8", 1'b1, 16'd4);
        tk();                  ex("R8", 1'b1, 16'd4);
        gset(1'b1);
        tk();                  ex("R8", 1'b1, 16'd4);

        // R12 count of zero means 65536
        wcfg(2'd0);
        wcnt(16'd0);
        tick = 1'b1;
        repeat (65536) cyc();
        tick = 1'b0;
        ex("R12", 1'b0, 16'd1);
        tk();                  ex("R12", 1'b1, 16'd0);

        cyc();
        cyc();
        finish_run();
    end
endmodule